// File: doc/BRIEF.md
# Memory-Mapped NAND Flash Bridge

This block lets a 32-bit bus master drive an 8-bit NAND flash device using ordinary loads and stores. Software picks the kind of NAND cycle through the address. One address bit raises the command latch strobe and another raises the address latch strobe. A third bit moves the access from the primary chip enable of the selected chip select to a shared secondary enable, which reaches the second die of a stacked package. With none of these bits set, the access is a plain data transfer. A halfword or word access is split by the block into two or four byte cycles on the NAND bus, least significant byte first. Each byte cycle pulses the write or read strobe low for a fixed number of clocks and then high for the same number.

The master starts an access with a one-cycle `bus_req` pulse. It then waits for the one-cycle `bus_ready` pulse, which carries read data on `bus_rdata`. When `bus_reg` is high, the access goes to two small registers instead of the NAND bus. Address bit 2 clear selects the control register, which holds one NAND-mode enable bit per chip select. Address bit 2 set selects the status register, which reports the synchronised ready/busy line. That line is a single wired-AND input shared by every attached die.

Top module: `nand_bridge`

## Requirements
- R1: A NAND access with `bus_addr[4]` set holds `nand_cle` high, and `nand_ale` low, for every byte cycle of that access.
- R2: A NAND access with `bus_addr[3]` set and `bus_addr[4]` clear holds `nand_ale` high. If both bits are set, only `nand_cle` rises. If neither is set, both strobes stay low.
- R3: During a NAND access with `bus_addr[SEC_BIT]` clear, exactly one of the primary enables is low: `nand_ce_n[bus_cs]`. With that bit set, only `nand_ce2_n` is low. All enables are high when the block is idle.
- R4: `bus_addr[1:0]` is ignored. `bus_size` 0 gives 1 byte cycle, 1 gives 2, and 2 or 3 give 4. A write drives `bus_wdata[8k+7:8k]` on `nand_dout` in byte cycle k, with k counting from 0.
- R5: A NAND read samples `nand_din` at the end of each low strobe phase. Byte k lands in `bus_rdata[8k+7:8k]`, and the unused upper bytes read zero.
- R6: Each byte cycle holds `nand_we_n` (write) or `nand_re_n` (read) low for PULSE clocks and then high for PULSE clocks. The two strobes are never low together. `bus_ready` is a single-cycle pulse that rises 2·PULSE·n clocks after the request edge, where n is the byte count.
- R7: Status register bit 0 is `nand_rb` (1 = ready) passed through two flops. A read issued one clock after `nand_rb` changes still returns the old value, and the other bits read zero.
- R8: Control register bit i (for i < NUM_CS) enables NAND mode for chip select i. It resets to 0, is written from `bus_wdata`, and reads back zero-extended. A register access returns `bus_ready` on the clock after the request edge.
- R9: A NAND access to a chip select whose enable bit is clear produces no strobe and no chip enable, returns `bus_ready` on the clock after the request edge, and reads zero.
- R10: A `bus_req` that arrives while an access is in progress is ignored: the running access keeps its byte count, strobes and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | One-cycle access request |
| bus_reg | input | 1 | 1 = register access, 0 = NAND access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cs | input | CSW | Chip select index of the access |
| bus_addr | input | ADDR_W | Byte address; bits 4, 3 and SEC_BIT select the cycle kind |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | NUM_CS | Primary chip enables, active low |
| nand_ce2_n | output | 1 | Secondary chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | NAND data out |
| nand_doe | output | 1 | Data output enable |
| nand_din | input | 8 | NAND data in |
| nand_rb | input | 1 | Wired-AND ready/busy, 1 = ready |

## Verification
The bench targets addresses with both latch bits set. A decoder without the command priority would raise both latch strobes together. It also sends byte and halfword accesses with random low address bits: a design that did not ignore those bits, or miscounted the bytes, would emit the wrong number of strobes or would shift the write lanes. The bench times status reads against changes on the ready line to catch a synchroniser that is one flop short. It mixes accesses to disabled chip selects, where a faulty design would pulse strobes or return stale data. It also sends requests while an access is running, which would restart or lengthen a transfer that did not lock out new requests.

// File: rtl/nand_bridge.sv
module nand_bridge #(
  parameter int NUM_CS  = 4,
  parameter int ADDR_W  = 16,
  parameter int SEC_BIT = 14,
  parameter int PULSE   = 2,
  localparam int CSW    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int CW     = $clog2(PULSE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_reg,
  input  logic              bus_we,
  input  logic [CSW-1:0]    bus_cs,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_ce2_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dout,
  output logic              nand_doe,
  input  logic [7:0]        nand_din,
  input  logic              nand_rb
);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [1:0]        idx, last;
  logic              wr, rb_s1, rb_s2;
  logic [31:0]       wdat, rdat;
  logic [NUM_CS-1:0] ctrl;

  wire phase_end = (cnt == CW'(PULSE - 1));

  assign nand_we_n = !(st == S_LOW && wr);
  assign nand_re_n = !(st == S_LOW && !wr);
  assign nand_doe  = (st != S_IDLE) && wr;
  assign nand_dout = wdat[{idx, 3'b000} +: 8];
  assign bus_rdata = rdat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      idx        <= '0;
      last       <= '0;
      wr         <= 1'b0;
      wdat       <= '0;
      rdat       <= '0;
      ctrl       <= '0;
      rb_s1      <= 1'b0;
      rb_s2      <= 1'b0;
      bus_ready  <= 1'b0;
      nand_ce_n  <= '1;
      nand_ce2_n <= 1'b1;
      nand_cle   <= 1'b0;
      nand_ale   <= 1'b0;
    end else begin
      rb_s1     <= nand_rb;
      rb_s2     <= rb_s1;
      bus_ready <= 1'b0;
      unique case (st)
        S_IDLE: if (bus_req) begin
          if (bus_reg) begin
            bus_ready <= 1'b1;
            rdat      <= bus_addr[2] ? {31'b0, rb_s2} : 32'(ctrl);
            if (bus_we && !bus_addr[2]) ctrl <= bus_wdata[NUM_CS-1:0];
          end else if (!ctrl[bus_cs]) begin
            bus_ready <= 1'b1;
            rdat      <= '0;
          end else begin
            st         <= S_LOW;
            cnt        <= '0;
            idx        <= '0;
            last       <= (bus_size == 2'd0) ? 2'd0 : (bus_size == 2'd1) ? 2'd1 : 2'd3;
            wr         <= bus_we;
            wdat       <= bus_wdata;
            rdat       <= '0;
            nand_ce_n  <= bus_addr[SEC_BIT] ? '1 : ~(NUM_CS'(1) << bus_cs);
            nand_ce2_n <= !bus_addr[SEC_BIT];
            nand_cle   <= bus_addr[4];
            nand_ale   <= bus_addr[3] && !bus_addr[4];
          end
        end
        S_LOW: begin
          if (phase_end) begin
            cnt <= '0;
            st  <= S_HIGH;
            if (!wr) rdat[{idx, 3'b000} +: 8] <= nand_din;
          end else cnt <= cnt + 1'b1;
        end
        S_HIGH: begin
          if (phase_end) begin
            cnt <= '0;
            if (idx == last) begin
              st         <= S_IDLE;
              bus_ready  <= 1'b1;
              nand_ce_n  <= '1;
              nand_ce2_n <= 1'b1;
              nand_cle   <= 1'b0;
              nand_ale   <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_LOW;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module nand_bridge_chk #(
  parameter int NUM_CS = 4,
  parameter int PULSE  = 2,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_reg,
  input logic [CSW-1:0]    bus_cs,
  input logic              bus_ready,
  input logic [NUM_CS-1:0] nand_ce_n,
  input logic              nand_ce2_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic [NUM_CS-1:0] ctrl
);
  logic [7:0] lowcnt;
  wire idle = (&nand_ce_n) && nand_ce2_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lowcnt <= '0;
    else lowcnt <= nand_we_n ? 8'd0 : lowcnt + 8'd1;

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nand_cle && nand_ale)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(!nand_we_n && !nand_re_n)); // R6
  AST_STROBE_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> ($countones(~nand_ce_n) + 32'(!nand_ce2_n) == 1)); // R3
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) bus_ready |=> !bus_ready); // R6
  AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (lowcnt == 8'(PULSE))); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_reg && idle && !bus_ready && !ctrl[bus_cs]) |=> (bus_ready && nand_we_n && nand_re_n && idle)); // R9
endmodule

bind nand_bridge nand_bridge_chk #(.NUM_CS(NUM_CS), .PULSE(PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_reg(bus_reg), .bus_cs(bus_cs),
  .bus_ready(bus_ready), .nand_ce_n(nand_ce_n), .nand_ce2_n(nand_ce2_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .ctrl(ctrl));

// File: tb/tb_nand_bridge.sv
`timescale 1ns/1ps
module tb_nand_bridge;
  localparam int NUM_CS = 4, ADDR_W = 16, SEC_BIT = 14, PULSE = 2;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_reg = 0, bus_we = 0;
  logic [1:0] bus_cs = 0;
  logic [ADDR_W-1:0] bus_addr = 0;
  logic [1:0] bus_size = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_ready;
  logic [NUM_CS-1:0] nand_ce_n;
  logic nand_ce2_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe, nand_rb = 1;
  logic [7:0] nand_dout, nand_din = 0;

  nand_bridge #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .SEC_BIT(SEC_BIT), .PULSE(PULSE)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, tick = 0;
  int nrec = 0, rdcnt = 0;
  logic [7:0] r_dout [8];
  logic r_cle [8], r_ale [8], r_isw [8], r_ce2 [8];
  logic [NUM_CS-1:0] r_ce [8];
  logic [NUM_CS-1:0] ctrl_m = 0;

  function automatic logic [7:0] rd_byte(int n);
    return 8'(n * 29 + 'h5B);
  endfunction

  always @(posedge nand_we_n or posedge nand_re_n) if (rst_n && nrec < 8) begin
    r_dout[nrec] = nand_dout; r_cle[nrec] = nand_cle; r_ale[nrec] = nand_ale;
    r_isw[nrec] = nand_doe; r_ce2[nrec] = nand_ce2_n; r_ce[nrec] = nand_ce_n;
    nrec++;
  end

  always @(negedge nand_re_n) if (rst_n) begin
    nand_din <= rd_byte(rdcnt);
    rdcnt++;
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", tick);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic access(bit reg_, bit we, int cs, logic [ADDR_W-1:0] a, int sz, logic [31:0] wd,
                        bit poke, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    nrec = 0;
    bus_reg = reg_; bus_we = we; bus_cs = 2'(cs); bus_addr = a; bus_size = 2'(sz); bus_wdata = wd;
    bus_req = 1;
    @(negedge clk);
    bus_req = 0;
    cyc = 1;
    while (!bus_ready && cyc < 200) begin
      if (poke && cyc == 2) begin bus_we = !we; bus_addr = ~a; bus_size = 0; end
      bus_req = poke && cyc == 2;
      @(negedge clk);
      cyc++;
    end
    bus_req = 0;
    rd = bus_rdata;
  endtask

  task automatic nand_op(bit we, int cs, logic [ADDR_W-1:0] a, int sz, logic [31:0] wd, bit poke);
    logic [31:0] rd, exp_rd;
    int cyc, nb, rd0, mism;
    bit en;
    logic [NUM_CS-1:0] exp_ce;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    en = ctrl_m[cs];
    rd0 = rdcnt;
    access(0, we, cs, a, sz, wd, poke, rd, cyc);
    if (!en) begin
      chk(nrec == 0, "R9", "strobes on disabled cs", 32'(nrec), 0);
      chk(cyc == 1, "R9", "latency disabled", 32'(cyc), 1);
      chk(rd == 0, "R9", "read data disabled", rd, 0);
      return;
    end
    chk(nrec == nb, "R4", "byte cycle count", 32'(nrec), 32'(nb));
    chk(cyc == nb * 2 * PULSE + 1, poke ? "R10" : "R6", "ready latency", 32'(cyc), 32'(nb * 2 * PULSE + 1));
    exp_ce = a[SEC_BIT] ? '1 : ~(4'b1 << cs);
    mism = 0;
    for (int k = 0; k < nb && k < nrec; k++) begin
      if (r_cle[k] !== a[4]) mism++;
      if (r_ale[k] !== (a[3] & ~a[4])) mism++;
      if (r_isw[k] !== we) mism++;
      if (r_ce2[k] !== !a[SEC_BIT] || r_ce[k] !== exp_ce) mism++;
      if (we && r_dout[k] !== wd[8*k +: 8]) mism++;
    end
    chk(mism == 0, "R1 R2 R3 R4", "per-byte strobe/enable/data mismatches", 32'(mism), 0);
    if (!we) begin
      exp_rd = 0;
      for (int k = 0; k < nb; k++) exp_rd[8*k +: 8] = rd_byte(rd0 + k);
      chk(rd == exp_rd, "R5", "read assembly", rd, exp_rd);
    end
  endtask

  task automatic set_ctrl(logic [3:0] m);
    logic [31:0] rd; int cyc;
    access(1, 1, 0, 16'h0, 2, {28'h0, m}, 0, rd, cyc);
    ctrl_m = m;
    access(1, 0, 0, 16'h0, 2, 0, 0, rd, cyc);
    chk(rd == {28'h0, m} && cyc == 1, "R8", "control readback", rd, {28'h0, m});
  endtask

  initial begin
    logic [31:0] rd; int cyc;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(bus_ready == 0 && nand_we_n && nand_re_n, "R6", "reset strobes idle", {bus_ready, nand_we_n, nand_re_n}, 3'b011);
    chk(&nand_ce_n && nand_ce2_n && !nand_cle && !nand_ale, "R3", "reset enables idle", {nand_ce_n, nand_ce2_n, nand_cle, nand_ale}, 7'b1111100);
    rst_n = 1;
    access(1, 0, 0, 16'h0, 2, 0, 0, rd, cyc);
    chk(rd == 0, "R8", "control reset value", rd, 0);
    nand_op(1, 1, 16'h0010, 0, 32'hA5, 0);
    set_ctrl(4'b0101);
    nand_op(1, 0, 16'h0010, 0, 32'h70, 0);
    nand_op(1, 0, 16'h000B, 1, 32'h1234, 0);
    nand_op(1, 2, 16'h0018, 0, 32'hFF, 0);
    nand_op(0, 0, 16'h0003, 2, 0, 0);
    nand_op(0, 2, 16'h4001, 3, 0, 0);
    nand_op(1, 1, 16'h0000, 2, 32'hDEADBEEF, 0);
    nand_op(1, 0, 16'h4002, 2, 32'hCAFEF00D, 1);
    nand_op(0, 2, 16'h0000, 1, 0, 1);
    @(negedge clk); nand_rb = 0;
    access(1, 0, 0, 16'h4, 2, 0, 0, rd, cyc);
    chk(rd == 1, "R7", "status before sync depth", rd, 1);
    access(1, 0, 0, 16'h4, 2, 0, 0, rd, cyc);
    chk(rd == 0, "R7", "status busy", rd, 0);
    nand_rb = 1;
    access(1, 0, 0, 16'h4, 2, 0, 0, rd, cyc);
    chk(rd == 0, "R7", "status still busy one clock after change", rd, 0);
    access(1, 0, 0, 16'h4, 2, 0, 0, rd, cyc);
    chk(rd == 1, "R7", "status ready", rd, 1);
    for (int i = 0; i < 160; i++) begin
      if (i % 25 == 0) set_ctrl(4'($urandom));
      nand_op($urandom % 2, $urandom % 4, 16'($urandom), $urandom % 4, $urandom, ($urandom % 8) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule